// File: doc/BRIEF.md
# Four-Slot In-Order Issue Unit

This block sits between instruction decode and four execution ports. It holds a group of up to four decoded instructions and, every cycle, decides which of the instructions still waiting may go out, strictly in program order. Each instruction carries a class code, two source register numbers and a destination register number. The ports are two integer ALUs that are not the same, a memory (load/store) port and a floating-point port. ALU A is the only one that shifts and multiplies. ALU B is the only one that resolves branches. A plain ALU operation may use either ALU.

The unit reports which entries issue this cycle and the port each one uses. A new group is accepted only when the held group is fully drained: the unit raises a refill request in the cycle in which the last waiting entries issue, or while it holds nothing. A group offered at that point with the load enable high is captured at the clock edge. A group offered at any other time is ignored.

Top module: `issue_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, no entry is granted and `refill_req` is 1.
- R2: A grant is given only to an entry that was loaded valid and has not issued yet. At most four grants are given per cycle, and each entry issues exactly once.
- R3: Entries issue in program order (index 0 first). If a waiting entry cannot issue, no entry after it issues in that cycle.
- R4: A plain ALU entry (class 1) takes ALU A (port code 1) if that ALU is still free this cycle, and otherwise ALU B (port code 2).
- R5: A shift/multiply entry (class 2) may issue only on ALU A (port code 1). A branch entry (class 3) may issue only on ALU B (port code 2).
- R6: At most one memory entry (class 4, port code 3) and at most one floating-point entry (class 5, port code 4) issue per cycle. No port is given to two entries in the same cycle.
- R7: A later entry does not issue in the same cycle as an earlier entry if either of its sources equals the earlier entry's nonzero destination. Register 0 never creates this conflict, and NOP entries neither produce nor consume.
- R8: A NOP entry (class 0) uses no port. It issues with port code 0 and does not stop the entries behind it.
- R9: `refill_req` is 1 exactly when every entry still waiting issues in this cycle, or when nothing is waiting. A group is captured at the edge only if `ld_en` and `refill_req` are both 1. Otherwise the load inputs have no effect.
- R10: An entry loaded with its valid bit at 0 is never granted and does not block the entries after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Offer of a new group |
| ld_valid | input | SLOTS | Valid bit per offered entry |
| ld_cls | input | 3*SLOTS | Class code per entry: 0 NOP, 1 ALU, 2 shift/mul, 3 branch, 4 memory, 5 FP |
| ld_src_a | input | REG_W*SLOTS | First source register per entry |
| ld_src_b | input | REG_W*SLOTS | Second source register per entry |
| ld_dst | input | REG_W*SLOTS | Destination register per entry (0 = none) |
| refill_req | output | 1 | Buffer drains this cycle; a group may be loaded |
| iss_grant | output | SLOTS | Entry issues this cycle |
| iss_port | output | 3*SLOTS | Port per granted entry: 0 none, 1 ALU A, 2 ALU B, 3 memory, 4 FP |

## Verification
A wrong waiting mask shows at the ports in the next cycle. An entry issues twice, an entry never issues, or `refill_req` rises too early or never rises, and the group that follows is then lost or taken too soon. A wrong free-port or hazard decision shows in the same cycle as a missing or extra grant or a wrong port code. Because of the program-order rule, such an error also moves the grants of every later entry. The sweep compares grants, ports and the refill request on every cycle against an independent model, across all class mixes of a group. So a divergence is caught in the cycle where it first occurs.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int CLS_W  = 3;
  localparam int PORT_W = 3;
  localparam int NPORT  = 4;

  localparam logic [CLS_W-1:0] CL_NOP = 3'd0;
  localparam logic [CLS_W-1:0] CL_ALU = 3'd1;
  localparam logic [CLS_W-1:0] CL_SHM = 3'd2;
  localparam logic [CLS_W-1:0] CL_BR  = 3'd3;
  localparam logic [CLS_W-1:0] CL_MEM = 3'd4;
  localparam logic [CLS_W-1:0] CL_FP  = 3'd5;

  localparam logic [PORT_W-1:0] PT_NONE = 3'd0;
  localparam logic [PORT_W-1:0] PT_ALUA = 3'd1;
  localparam logic [PORT_W-1:0] PT_ALUB = 3'd2;
  localparam logic [PORT_W-1:0] PT_MEM  = 3'd3;
  localparam logic [PORT_W-1:0] PT_FP   = 3'd4;

  typedef struct packed {
    logic                ok;
    logic [PORT_W-1:0]   port;
  } pick_t;

  // free-port bit per port code: bit0 ALU A, bit1 ALU B, bit2 memory, bit3 FP
  function automatic logic [NPORT-1:0] port_bit(input logic [PORT_W-1:0] p);
    case (p)
      PT_ALUA: port_bit = 4'b0001;
      PT_ALUB: port_bit = 4'b0010;
      PT_MEM:  port_bit = 4'b0100;
      PT_FP:   port_bit = 4'b1000;
      default: port_bit = 4'b0000;
    endcase
  endfunction

  // choose a port for a class given the ports still free this cycle
  function automatic pick_t pick_port(input logic [CLS_W-1:0] c,
                                      input logic [NPORT-1:0] free);
    pick_t r;
    r.ok   = 1'b0;
    r.port = PT_NONE;
    case (c)
      CL_NOP: r.ok = 1'b1;
      CL_ALU: begin
        if (free[0])      begin r.ok = 1'b1; r.port = PT_ALUA; end
        else if (free[1]) begin r.ok = 1'b1; r.port = PT_ALUB; end
      end
      CL_SHM: if (free[0]) begin r.ok = 1'b1; r.port = PT_ALUA; end
      CL_BR:  if (free[1]) begin r.ok = 1'b1; r.port = PT_ALUB; end
      CL_MEM: if (free[2]) begin r.ok = 1'b1; r.port = PT_MEM;  end
      CL_FP:  if (free[3]) begin r.ok = 1'b1; r.port = PT_FP;   end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/issue_buffer.sv
module issue_buffer
  import issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SLOTS-1:0]       in_valid,
  input  logic [SLOTS*CLS_W-1:0] in_cls,
  input  logic [SLOTS*REG_W-1:0] in_sa,
  input  logic [SLOTS*REG_W-1:0] in_sb,
  input  logic [SLOTS*REG_W-1:0] in_dst,
  input  logic [SLOTS-1:0]       done,
  output logic [SLOTS-1:0]       pend,
  output logic [SLOTS*CLS_W-1:0] cls,
  output logic [SLOTS*REG_W-1:0] sa,
  output logic [SLOTS*REG_W-1:0] sb,
  output logic [SLOTS*REG_W-1:0] dst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      cls  <= '0;
      sa   <= '0;
      sb   <= '0;
      dst  <= '0;
    end else if (load) begin
      pend <= in_valid;
      cls  <= in_cls;
      sa   <= in_sa;
      sb   <= in_sb;
      dst  <= in_dst;
    end else begin
      pend <= pend & ~done;
    end
  end
endmodule

// File: rtl/hazard_matrix.sv
module hazard_matrix
  import issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int REG_W = 5
) (
  input  logic [SLOTS*CLS_W-1:0]   cls,
  input  logic [SLOTS*REG_W-1:0]   sa,
  input  logic [SLOTS*REG_W-1:0]   sb,
  input  logic [SLOTS*REG_W-1:0]   dst,
  output logic [SLOTS*SLOTS-1:0]   hz
);
  // hz[j*SLOTS+i]: younger entry j reads what older entry i writes
  function automatic logic reads_from(input logic [REG_W-1:0] a,
                                      input logic [REG_W-1:0] b,
                                      input logic [REG_W-1:0] d);
    return (d != '0) && ((a == d) || (b == d));
  endfunction

  for (genvar j = 0; j < SLOTS; j++) begin : g_young
    for (genvar i = 0; i < SLOTS; i++) begin : g_old
      if (i < j) begin : g_pair
        assign hz[j*SLOTS+i] = (cls[i*CLS_W +: CLS_W] != CL_NOP) &&
                               (cls[j*CLS_W +: CLS_W] != CL_NOP) &&
                               reads_from(sa[j*REG_W +: REG_W],
                                          sb[j*REG_W +: REG_W],
                                          dst[i*REG_W +: REG_W]);
      end else begin : g_none
        assign hz[j*SLOTS+i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/slot_select.sv
module slot_select
  import issue_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]        pend,
  input  logic [SLOTS*CLS_W-1:0]  cls,
  input  logic [SLOTS*SLOTS-1:0]  hz,
  output logic [SLOTS-1:0]        grant,
  output logic [SLOTS*PORT_W-1:0] port,
  output logic [SLOTS-1:0]        stall_at
);
  logic [NPORT-1:0] free;
  logic             blocked;
  logic             raw;
  pick_t            pk;

  always_comb begin
    free     = '1;
    blocked  = 1'b0;
    grant    = '0;
    port     = '0;
    stall_at = '0;
    raw      = 1'b0;
    pk       = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (pend[j] && !blocked) begin
        raw = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
          if (grant[i] && hz[j*SLOTS+i]) raw = 1'b1;
        end
        pk = pick_port(cls[j*CLS_W +: CLS_W], free);
        if (pk.ok && !raw) begin
          grant[j]                = 1'b1;
          port[j*PORT_W +: PORT_W] = pk.port;
          free                    = free & ~port_bit(pk.port);
        end else begin
          blocked     = 1'b1;
          stall_at[j] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/issue_unit.sv
module issue_unit
  import issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int REG_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [SLOTS-1:0]        ld_valid,
  input  logic [SLOTS*3-1:0]      ld_cls,
  input  logic [SLOTS*REG_W-1:0]  ld_src_a,
  input  logic [SLOTS*REG_W-1:0]  ld_src_b,
  input  logic [SLOTS*REG_W-1:0]  ld_dst,
  output logic                    refill_req,
  output logic [SLOTS-1:0]        iss_grant,
  output logic [SLOTS*3-1:0]      iss_port
);
  logic [SLOTS-1:0]        pend;
  logic [SLOTS*CLS_W-1:0]  b_cls;
  logic [SLOTS*REG_W-1:0]  b_sa, b_sb, b_dst;
  logic [SLOTS*SLOTS-1:0]  hz;
  logic [SLOTS-1:0]        stall_at;
  logic                    load_fire;
  logic [SLOTS-1:0]        left_after;

  assign left_after = pend & ~iss_grant;
  assign refill_req = (left_after == '0);
  assign load_fire  = ld_en && refill_req;

  issue_buffer #(.SLOTS(SLOTS), .REG_W(REG_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load_fire),
    .in_valid(ld_valid), .in_cls(ld_cls), .in_sa(ld_src_a),
    .in_sb(ld_src_b), .in_dst(ld_dst), .done(iss_grant),
    .pend(pend), .cls(b_cls), .sa(b_sa), .sb(b_sb), .dst(b_dst)
  );

  hazard_matrix #(.SLOTS(SLOTS), .REG_W(REG_W)) u_hz (
    .cls(b_cls), .sa(b_sa), .sb(b_sb), .dst(b_dst), .hz(hz)
  );

  slot_select #(.SLOTS(SLOTS)) u_sel (
    .pend(pend), .cls(b_cls), .hz(hz),
    .grant(iss_grant), .port(iss_port), .stall_at(stall_at)
  );
endmodule

// File: rtl/issue_unit_chk.sv
module issue_unit_chk
  import issue_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int REG_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ld_en,
  input logic [SLOTS-1:0]       ld_valid,
  input logic                   refill_req,
  input logic [SLOTS-1:0]       iss_grant,
  input logic [SLOTS*3-1:0]     iss_port,
  input logic [SLOTS-1:0]       pend,
  input logic [SLOTS*3-1:0]     b_cls,
  input logic [SLOTS*REG_W-1:0] b_sa,
  input logic [SLOTS*REG_W-1:0] b_sb,
  input logic [SLOTS*REG_W-1:0] b_dst
);
  logic [SLOTS-1:0] on_a, on_b, on_m, on_f;
  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      on_a[k] = iss_grant[k] && (iss_port[k*3 +: 3] == PT_ALUA);
      on_b[k] = iss_grant[k] && (iss_port[k*3 +: 3] == PT_ALUB);
      on_m[k] = iss_grant[k] && (iss_port[k*3 +: 3] == PT_MEM);
      on_f[k] = iss_grant[k] && (iss_port[k*3 +: 3] == PT_FP);
    end
  end

  p_grant_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant & ~pend) == '0);

  p_port_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(on_a) <= 1 && $countones(on_b) <= 1 &&
    $countones(on_m) <= 1 && $countones(on_f) <= 1);

  p_load_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && refill_req |=> pend == $past(ld_valid));

  p_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_req |=> pend == $past(pend & ~iss_grant));

  for (genvar j = 0; j < SLOTS; j++) begin : g_chk
    p_shm_on_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant[j] && b_cls[j*3 +: 3] == CL_SHM |-> iss_port[j*3 +: 3] == PT_ALUA);
    p_br_on_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant[j] && b_cls[j*3 +: 3] == CL_BR |-> iss_port[j*3 +: 3] == PT_ALUB);
    p_nop_no_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant[j] && b_cls[j*3 +: 3] == CL_NOP |-> iss_port[j*3 +: 3] == PT_NONE);
    for (genvar i = 0; i < j; i++) begin : g_old
      p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant[j] |-> iss_grant[i] || !pend[i]);
      p_no_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant[j] && iss_grant[i] && b_cls[i*3 +: 3] != CL_NOP &&
        b_cls[j*3 +: 3] != CL_NOP && b_dst[i*REG_W +: REG_W] != '0
        |-> b_sa[j*REG_W +: REG_W] != b_dst[i*REG_W +: REG_W] &&
            b_sb[j*REG_W +: REG_W] != b_dst[i*REG_W +: REG_W]);
    end
  end
endmodule

bind issue_unit issue_unit_chk #(.SLOTS(SLOTS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_valid(ld_valid),
  .refill_req(refill_req), .iss_grant(iss_grant), .iss_port(iss_port),
  .pend(pend), .b_cls(b_cls), .b_sa(b_sa), .b_sb(b_sb), .b_dst(b_dst)
);

// File: tb/issue_unit_test.sv
`timescale 1ns/1ps
module issue_unit_test;
  localparam int N = 4;
  localparam int RW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_en = 1'b0;
  logic [N-1:0]    ld_valid = '0;
  logic [N*3-1:0]  ld_cls = '0;
  logic [N*RW-1:0] ld_src_a = '0, ld_src_b = '0, ld_dst = '0;
  logic            refill_req;
  logic [N-1:0]    iss_grant;
  logic [N*3-1:0]  iss_port;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  int m_cls[N], m_sa[N], m_sb[N], m_dst[N];
  bit m_pend[N];
  bit e_grant[N];
  int e_port[N];
  bit e_refill;
  // offered group
  int o_cls[N], o_sa[N], o_sb[N], o_dst[N];
  bit o_valid[N];

  always #10 clk = ~clk;

  issue_unit #(.SLOTS(N), .REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_valid(ld_valid),
    .ld_cls(ld_cls), .ld_src_a(ld_src_a), .ld_src_b(ld_src_b),
    .ld_dst(ld_dst), .refill_req(refill_req), .iss_grant(iss_grant),
    .iss_port(iss_port)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected issue decision from the requirements
  task automatic model_issue();
    bit ua = 0, ub = 0, um = 0, uf = 0, stop = 0;
    int left = 0;
    for (int j = 0; j < N; j++) begin
      e_grant[j] = 0;
      e_port[j]  = 0;
      if (m_pend[j] && !stop) begin
        bit dep = 0;
        int pt = 0;
        for (int i = 0; i < j; i++)
          if (e_grant[i] && m_cls[i] != 0 && m_cls[j] != 0 && m_dst[i] != 0 &&
              (m_sa[j] == m_dst[i] || m_sb[j] == m_dst[i])) dep = 1;
        case (m_cls[j])
          1: pt = !ua ? 1 : (!ub ? 2 : 0);
          2: pt = !ua ? 1 : 0;
          3: pt = !ub ? 2 : 0;
          4: pt = !um ? 3 : 0;
          5: pt = !uf ? 4 : 0;
          default: pt = 0;
        endcase
        if ((m_cls[j] == 0 || pt != 0) && !dep) begin
          e_grant[j] = 1;
          e_port[j]  = pt;
          if (pt == 1) ua = 1;
          if (pt == 2) ub = 1;
          if (pt == 3) um = 1;
          if (pt == 4) uf = 1;
        end else stop = 1;
      end
      if (m_pend[j] && !e_grant[j]) left++;
    end
    e_refill = (left == 0);
  endtask

  task automatic drive_offer();
    for (int k = 0; k < N; k++) begin
      ld_valid[k]          = o_valid[k];
      ld_cls[k*3 +: 3]     = 3'(o_cls[k]);
      ld_src_a[k*RW +: RW] = RW'(o_sa[k]);
      ld_src_b[k*RW +: RW] = RW'(o_sb[k]);
      ld_dst[k*RW +: RW]   = RW'(o_dst[k]);
    end
  endtask

  task automatic make_group(input int g);
    int q = g;
    for (int k = 0; k < N; k++) begin
      o_cls[k] = q % 6;
      q = q / 6;
      o_sa[k]  = (g * 5 + k * 3 + 1) % 4;
      o_sb[k]  = (g * 3 + k) % 4;
      o_dst[k] = (g + k * 7 + 2) % 4;
      o_valid[k] = !((g % 5 == 0) && (k == (g / 5) % 4));
    end
  endtask

  // one cycle: compare at the negative edge, update model, cross the posedge
  task automatic cycle(output bit loaded);
    string tg;
    model_issue();
    for (int k = 0; k < N; k++) begin
      if (!m_valid_or_pend(k)) tg = "R10 grant";
      else tg = "R2 R3 R7 grant";
      check(iss_grant[k] == e_grant[k], tg, iss_grant[k], e_grant[k]);
      if (e_grant[k]) begin
        case (m_cls[k])
          0: tg = "R8 port";
          1: tg = "R4 port";
          2, 3: tg = "R5 port";
          default: tg = "R6 port";
        endcase
        check(iss_port[k*3 +: 3] == 3'(e_port[k]), tg, iss_port[k*3 +: 3], e_port[k]);
      end
    end
    check(refill_req == e_refill, "R9 refill", refill_req, e_refill);
    loaded = e_refill && ld_en;
    for (int k = 0; k < N; k++) begin
      if (loaded) begin
        m_pend[k] = o_valid[k];
        m_cls[k] = o_cls[k]; m_sa[k] = o_sa[k];
        m_sb[k] = o_sb[k];   m_dst[k] = o_dst[k];
      end else if (e_grant[k]) m_pend[k] = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  bit m_loaded_valid[N];
  function automatic bit m_valid_or_pend(input int k);
    return m_pend[k];
  endfunction

  initial begin
    for (int k = 0; k < N; k++) begin
      m_pend[k] = 0; m_cls[k] = 0; m_sa[k] = 0; m_sb[k] = 0; m_dst[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(iss_grant == '0, "R1 grant in reset", iss_grant, 0);
    check(refill_req == 1'b1, "R1 refill in reset", refill_req, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(iss_grant == '0, "R1 grant after reset", iss_grant, 0);
    check(refill_req == 1'b1, "R1 refill after reset", refill_req, 1);
    begin
      int g = 0;
      int cyc = 0;
      bit ld;
      while (g < 1296) begin
        make_group(g);
        drive_offer();
        ld_en = (cyc % 9 != 4);
        cycle(ld);
        if (ld) g++;
        cyc++;
      end
      ld_en = 1'b0;
      repeat (5) cycle(ld);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=timeout expected=drained");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule